// File: doc/BRIEF.md
# Data Address Compare Unit

This block watches the load and store accesses of a processor pipeline and compares each effective address against two compare values. The two values can act as two independent exact comparators, as a value with a bit mask, or as the lower and upper bounds of an address window, either inside or outside it. Each comparison is qualified by the kind of access (load or store), the privilege level (user or supervisor) and the data address space bit.

A match never stalls or blocks the access. Matches are gathered while the instruction is in flight and are acted on only when the instruction ends. On normal completion the unit sets sticky status bits and raises a precise event. If the instruction ends with a data storage exception, the event is imprecise and a sticky imprecise flag is set as well. Flushed instructions discard their matches. So do load-multiple or store-multiple instructions stopped by a critical or external interrupt. The second half of a misaligned access that was split into two transfers never matches. Status is recorded whatever the global debug enable says; only the interrupt request depends on it.

Top module: `dac_unit`

## Requirements
- R1: After reset, `stat_hit`, `stat_imprecise`, `evt_valid`, `evt_precise` and `dbg_irq` are all zero.
- R2: In exact mode (`cmp_mode`=0), comparator A matches when the access address equals `cmp_val_a` and comparator B when it equals `cmp_val_b`; a reported match of A sets `stat_hit[0]`, of B sets `stat_hit[1]`.
- R3: A comparator's qualifier word enables bit 0 loads, bit 1 stores, bit 2 user mode, bit 3 supervisor mode, bit 4 space 0, bit 5 space 1; an access matches only if its kind, privilege and space bits are all enabled. Paired modes use the qualifier of A.
- R4: In masked mode (`cmp_mode`=1), a match occurs when `((addr ^ cmp_val_a) & cmp_val_b) == 0`; a reported match sets both status bits.
- R5: In inside-range mode (`cmp_mode`=2) a match occurs when `cmp_val_a <= addr < cmp_val_b`; in outside-range mode (`cmp_mode`=3) it occurs for every other address. A reported match sets both status bits.
- R6: Matches are held pending and do not touch the status bits until the instruction ends; an access in the same cycle as the end is included. One cycle after `ins_complete`, the pending matches are ORed into `stat_hit` and `evt_valid` and `evt_precise` are 1 for one cycle.
- R7: When the instruction ends with `ins_dsi`, one cycle later the pending matches are ORed into `stat_hit`, `stat_imprecise` is set, `evt_valid` is 1 and `evt_precise` is 0. `ins_dsi` takes priority over `ins_complete`.
- R8: `dbg_irq` equals `evt_valid` AND `dbg_global_en`; status bits are recorded when `dbg_global_en` is 0.
- R9: An access with `acc_second_half` set never produces a match.
- R10: `ins_flush` or `ins_intr_abort` discards every pending match, including one in the same cycle, with no status change and no event, and has priority over completion.
- R11: Status bits are sticky; `stat_clr` clears `stat_hit` and `stat_imprecise` one cycle later, and a report in the same cycle as the clear leaves only the new bits set.
- R12: An instruction that ends with no pending match produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_mode | input | 2 | 0 exact, 1 masked, 2 inside range, 3 outside range |
| cmp_val_a | input | ADDR_W | Compare value A (lower bound / base) |
| cmp_val_b | input | ADDR_W | Compare value B (upper bound / mask) |
| cmp_qual_a | input | 6 | Qualifier of comparator A |
| cmp_qual_b | input | 6 | Qualifier of comparator B |
| dbg_global_en | input | 1 | Global debug enable, gates the interrupt request |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Effective address of the access |
| acc_store | input | 1 | 1 store, 0 load |
| acc_super | input | 1 | 1 supervisor, 0 user |
| acc_space | input | 1 | Data address space bit |
| acc_second_half | input | 1 | Second transfer of a split misaligned access |
| ins_complete | input | 1 | Instruction completes normally |
| ins_dsi | input | 1 | Instruction ends with a data storage exception |
| ins_flush | input | 1 | Instruction flushed |
| ins_intr_abort | input | 1 | Multiple-word transfer stopped by an interrupt |
| stat_clr | input | 1 | Clear the sticky status bits |
| stat_hit | output | 2 | Sticky match status per comparator |
| stat_imprecise | output | 1 | Sticky imprecise-event flag |
| evt_valid | output | 1 | One-cycle event pulse |
| evt_precise | output | 1 | Event is precise (return to next instruction) |
| dbg_irq | output | 1 | Debug interrupt request |

## Verification
A wrong pending state stays hidden until the instruction ends and then shows one cycle later as a wrong `stat_hit` value or a missing or extra `evt_valid` pulse, so the bench ends instructions often and compares every output on every cycle against a behavioural model. A wrong comparator result surfaces at the first completion after the offending access, and a wrong sticky state persists until a clear, so it is seen on every later cycle. The directed cases hit the range boundaries, the mask, each qualifier bit and the priority between ending, flushing and clearing in the same cycle.

// File: rtl/dac_pkg.sv
`timescale 1ns/1ps
package dac_pkg;
   typedef enum logic [1:0] {
      CMP_EXACT   = 2'd0,
      CMP_MASKED  = 2'd1,
      CMP_INSIDE  = 2'd2,
      CMP_OUTSIDE = 2'd3
   } cmp_mode_e;

   // bit 0 load, 1 store, 2 user, 3 supervisor, 4 space 0, 5 space 1
   typedef struct packed {
      logic sp1;
      logic sp0;
      logic sup;
      logic usr;
      logic st;
      logic ld;
   } acc_qual_t;

   localparam int QUAL_W  = $bits(acc_qual_t);
   localparam int NUM_CMP = 2;
endpackage

// File: rtl/dac_lane.sv
`timescale 1ns/1ps
module dac_lane #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [ADDR_W-1:0]  cmp_val,
   input  dac_pkg::acc_qual_t qual,
   input  logic               acc_store,
   input  logic               acc_super,
   input  logic               acc_space,
   output logic               qual_ok,
   output logic               addr_eq,
   output logic               addr_ge
);
   logic kind_ok, priv_ok, space_ok;

   always_comb begin
      kind_ok  = acc_store ? qual.st  : qual.ld;
      priv_ok  = acc_super ? qual.sup : qual.usr;
      space_ok = acc_space ? qual.sp1 : qual.sp0;
      qual_ok  = kind_ok && priv_ok && space_ok;
      addr_eq  = (acc_addr == cmp_val);
      addr_ge  = (acc_addr >= cmp_val);
   end

   // equality must imply the lower-bound comparison used by range modes
   always_comb begin
      assert_eq_implies_ge_R5 : assert (!addr_eq || addr_ge);
   end
endmodule

// File: rtl/dac_pair_combine.sv
`timescale 1ns/1ps
module dac_pair_combine #(
   parameter int ADDR_W    = 32,
   parameter bit HAS_MASK  = 1'b1,
   parameter bit HAS_RANGE = 1'b1
) (
   input  dac_pkg::cmp_mode_e mode,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [ADDR_W-1:0]  val_a,
   input  logic [ADDR_W-1:0]  val_b,
   input  logic [1:0]         qual_ok,
   input  logic [1:0]         addr_eq,
   input  logic [1:0]         addr_ge,
   output logic [1:0]         hit
);
   import dac_pkg::*;

   logic mask_hit;
   logic in_hit;
   logic out_hit;

   generate
      if (HAS_MASK) begin : g_mask
         assign mask_hit = ~|((acc_addr ^ val_a) & val_b);
      end else begin : g_nomask
         assign mask_hit = 1'b0;
      end

      if (HAS_RANGE) begin : g_range
         assign in_hit  = addr_ge[0] & ~addr_ge[1];
         assign out_hit = ~in_hit;
      end else begin : g_norange
         assign in_hit  = 1'b0;
         assign out_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         CMP_EXACT:   hit = qual_ok & addr_eq;
         CMP_MASKED:  hit = {2{qual_ok[0] & mask_hit}};
         CMP_INSIDE:  hit = {2{qual_ok[0] & in_hit}};
         CMP_OUTSIDE: hit = {2{qual_ok[0] & out_hit}};
         default:     hit = 2'b00;
      endcase
   end

   // paired modes always flag both comparators together
   always_comb begin
      if (mode != CMP_EXACT)
         assert_pair_both_R4 : assert (hit == 2'b00 || hit == 2'b11);
   end
endmodule

// File: rtl/dac_pend_track.sv
`timescale 1ns/1ps
module dac_pend_track #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] hit_now,
   input  logic             ins_complete,
   input  logic             ins_dsi,
   input  logic             ins_flush,
   input  logic             ins_intr_abort,
   input  logic             stat_clr,
   output logic [LANES-1:0] pend_bits,
   output logic [LANES-1:0] stat_hit,
   output logic             stat_imprecise,
   output logic             evt_valid,
   output logic             evt_precise
);
   logic [LANES-1:0] pend_q;
   logic [LANES-1:0] gathered;
   logic             drop;
   logic             report;
   logic             any_hit;

   always_comb begin
      gathered = pend_q | hit_now;
      any_hit  = |gathered;
      drop     = ins_flush | ins_intr_abort;
      report   = (ins_complete | ins_dsi) & ~drop;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q         <= '0;
         stat_hit       <= '0;
         stat_imprecise <= 1'b0;
         evt_valid      <= 1'b0;
         evt_precise    <= 1'b0;
      end else begin
         pend_q         <= (drop | report) ? '0 : gathered;
         stat_hit       <= (stat_clr ? '0 : stat_hit) | (report ? gathered : '0);
         stat_imprecise <= (stat_clr ? 1'b0 : stat_imprecise) | (report & ins_dsi & any_hit);
         evt_valid      <= report & any_hit;
         evt_precise    <= report & any_hit & ~ins_dsi;
      end
   end

   assign pend_bits = pend_q;

   assert_evt_has_status_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (stat_hit != '0));

   assert_evt_needs_end_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> $past(ins_complete || ins_dsi));

   assert_imprecise_flag_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !evt_precise) |-> stat_imprecise);

   assert_drop_silent_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (ins_flush || ins_intr_abort) |=> (!evt_valid && pend_bits == '0));

   assert_sticky_imp_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_imprecise) |-> $past(stat_clr));

   assert_sticky_hit_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_hit & ~$past(stat_hit)) == '0 && !$past(stat_clr)) |-> (stat_hit == $past(stat_hit)));
endmodule

// File: rtl/dac_unit.sv
`timescale 1ns/1ps
module dac_unit #(
   parameter int ADDR_W    = 32,
   parameter bit HAS_MASK  = 1'b1,
   parameter bit HAS_RANGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmp_mode,
   input  logic [ADDR_W-1:0] cmp_val_a,
   input  logic [ADDR_W-1:0] cmp_val_b,
   input  logic [5:0]        cmp_qual_a,
   input  logic [5:0]        cmp_qual_b,
   input  logic              dbg_global_en,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_store,
   input  logic              acc_super,
   input  logic              acc_space,
   input  logic              acc_second_half,
   input  logic              ins_complete,
   input  logic              ins_dsi,
   input  logic              ins_flush,
   input  logic              ins_intr_abort,
   input  logic              stat_clr,
   output logic [1:0]        stat_hit,
   output logic              stat_imprecise,
   output logic              evt_valid,
   output logic              evt_precise,
   output logic              dbg_irq
);
   import dac_pkg::*;

   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_width
         $error("dac_unit: ADDR_W must lie in 8..64");
      end
      if (QUAL_W != 6) begin : g_bad_qual
         $error("dac_unit: qualifier word must be 6 bits");
      end
   endgenerate

   logic [ADDR_W-1:0] val_arr  [NUM_CMP];
   acc_qual_t         qual_arr [NUM_CMP];
   logic [NUM_CMP-1:0] lane_ok, lane_eq, lane_ge;
   logic [NUM_CMP-1:0] raw_hit, hit_now, pend_bits;
   cmp_mode_e          mode;

   assign val_arr[0]  = cmp_val_a;
   assign val_arr[1]  = cmp_val_b;
   assign qual_arr[0] = acc_qual_t'(cmp_qual_a);
   assign qual_arr[1] = acc_qual_t'(cmp_qual_b);
   assign mode        = cmp_mode_e'(cmp_mode);

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_lane
         dac_lane #(.ADDR_W(ADDR_W)) u_lane (
            .acc_addr  (acc_addr),
            .cmp_val   (val_arr[i]),
            .qual      (qual_arr[i]),
            .acc_store (acc_store),
            .acc_super (acc_super),
            .acc_space (acc_space),
            .qual_ok   (lane_ok[i]),
            .addr_eq   (lane_eq[i]),
            .addr_ge   (lane_ge[i])
         );
      end
   endgenerate

   dac_pair_combine #(
      .ADDR_W    (ADDR_W),
      .HAS_MASK  (HAS_MASK),
      .HAS_RANGE (HAS_RANGE)
   ) u_combine (
      .mode     (mode),
      .acc_addr (acc_addr),
      .val_a    (cmp_val_a),
      .val_b    (cmp_val_b),
      .qual_ok  (lane_ok),
      .addr_eq  (lane_eq),
      .addr_ge  (lane_ge),
      .hit      (raw_hit)
   );

   // the second transfer of a split access never takes part
   assign hit_now = (acc_valid && !acc_second_half) ? raw_hit : '0;

   dac_pend_track #(.LANES(NUM_CMP)) u_track (
      .clk            (clk),
      .rst_n          (rst_n),
      .hit_now        (hit_now),
      .ins_complete   (ins_complete),
      .ins_dsi        (ins_dsi),
      .ins_flush      (ins_flush),
      .ins_intr_abort (ins_intr_abort),
      .stat_clr       (stat_clr),
      .pend_bits      (pend_bits),
      .stat_hit       (stat_hit),
      .stat_imprecise (stat_imprecise),
      .evt_valid      (evt_valid),
      .evt_precise    (evt_precise)
   );

   assign dbg_irq = evt_valid & dbg_global_en;

   assert_split_no_pend_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_second_half && !ins_complete && !ins_dsi && !ins_flush && !ins_intr_abort)
      |=> (pend_bits == $past(pend_bits)));

   assert_pend_until_end_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_complete && !ins_dsi && !stat_clr) |=> (stat_hit == $past(stat_hit)));
endmodule

// File: tb/dac_unit_tb.sv
`timescale 1ns/1ps
module dac_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cmp_mode = 2'd0;
   logic [31:0] cmp_val_a = 32'h1000, cmp_val_b = 32'h2000;
   logic [5:0]  cmp_qual_a = 6'h3F, cmp_qual_b = 6'h3F;
   logic        dbg_global_en = 1'b1;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_store = 1'b0, acc_super = 1'b0, acc_space = 1'b0, acc_second_half = 1'b0;
   logic        ins_complete = 1'b0, ins_dsi = 1'b0, ins_flush = 1'b0, ins_intr_abort = 1'b0;
   logic        stat_clr = 1'b0;
   logic [1:0]  stat_hit;
   logic        stat_imprecise, evt_valid, evt_precise, dbg_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dac_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode), .cmp_val_a(cmp_val_a),
      .cmp_val_b(cmp_val_b), .cmp_qual_a(cmp_qual_a), .cmp_qual_b(cmp_qual_b),
      .dbg_global_en(dbg_global_en), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_store(acc_store), .acc_super(acc_super), .acc_space(acc_space),
      .acc_second_half(acc_second_half), .ins_complete(ins_complete), .ins_dsi(ins_dsi),
      .ins_flush(ins_flush), .ins_intr_abort(ins_intr_abort), .stat_clr(stat_clr),
      .stat_hit(stat_hit), .stat_imprecise(stat_imprecise), .evt_valid(evt_valid),
      .evt_precise(evt_precise), .dbg_irq(dbg_irq)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   function automatic logic [1:0] ref_hit(input logic [1:0] md, input logic [31:0] a, input logic [31:0] b,
                                          input logic [5:0] qa, input logic [5:0] qb, input logic [31:0] ad,
                                          input logic st, input logic su, input logic sp);
      bit ok_a, ok_b;
      ok_a = qa[st ? 1 : 0] && qa[su ? 3 : 2] && qa[sp ? 5 : 4];
      ok_b = qb[st ? 1 : 0] && qb[su ? 3 : 2] && qb[sp ? 5 : 4];
      if (md == 2'd0) return {ok_b && (ad == b), ok_a && (ad == a)};
      if (!ok_a) return 2'b00;
      if (md == 2'd1) return (((ad ^ a) & b) == 0) ? 2'b11 : 2'b00;
      if (md == 2'd2) return (ad >= a && ad < b) ? 2'b11 : 2'b00;
      return (ad < a || ad >= b) ? 2'b11 : 2'b00;
   endfunction

   logic [1:0] m_pend, m_stat;
   logic       m_imp, m_evt, m_prec;

   always @(posedge clk or negedge rst_n) begin
      logic [1:0] h, tot;
      bit rep;
      if (!rst_n) begin
         m_pend <= 0; m_stat <= 0; m_imp <= 0; m_evt <= 0; m_prec <= 0;
      end else begin
         h   = (acc_valid && !acc_second_half) ?
               ref_hit(cmp_mode, cmp_val_a, cmp_val_b, cmp_qual_a, cmp_qual_b, acc_addr, acc_store, acc_super, acc_space) : 2'b00;
         tot = m_pend | h;
         rep = (ins_complete || ins_dsi) && !(ins_flush || ins_intr_abort);
         m_pend <= (rep || ins_flush || ins_intr_abort) ? 2'b00 : tot;
         m_stat <= (stat_clr ? 2'b00 : m_stat) | (rep ? tot : 2'b00);
         m_imp  <= (stat_clr ? 1'b0 : m_imp) | (rep && ins_dsi && tot != 0);
         m_evt  <= rep && tot != 0;
         m_prec <= rep && tot != 0 && !ins_dsi;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(stat_hit == m_stat, "R2 stat_hit vs model", stat_hit, m_stat);
         chk(stat_imprecise == m_imp, "R7 stat_imprecise vs model", stat_imprecise, m_imp);
         chk(evt_valid == m_evt, "R6 evt_valid vs model", evt_valid, m_evt);
         chk(evt_precise == m_prec, "R7 evt_precise vs model", evt_precise, m_prec);
         chk(dbg_irq == (m_evt && dbg_global_en), "R8 dbg_irq vs model", dbg_irq, m_evt && dbg_global_en);
      end
   end

   // ---------------- directed stimulus helpers ----------------
   // endk bits: 0 complete, 1 dsi, 2 flush, 3 interrupt abort
   task automatic cyc(input bit av, input logic [31:0] ad, input bit hf, input logic [3:0] endk, input bit clr);
      @(negedge clk);
      acc_valid = av; acc_addr = ad; acc_second_half = hf;
      ins_complete = endk[0]; ins_dsi = endk[1]; ins_flush = endk[2]; ins_intr_abort = endk[3];
      stat_clr = clr;
      @(negedge clk);
      acc_valid = 0; acc_second_half = 0;
      ins_complete = 0; ins_dsi = 0; ins_flush = 0; ins_intr_abort = 0; stat_clr = 0;
      #1;
   endtask

   task automatic expect_out(input string req, input logic [5:0] exp);
      logic [5:0] act;
      act = {stat_hit, stat_imprecise, evt_valid, evt_precise, dbg_irq};
      chk(act === exp, req, act, exp);
   endtask

   task automatic access(input logic [31:0] ad);
      cyc(1, ad, 0, 4'b0000, 0);
   endtask

   task automatic end_ins(input logic [3:0] k);
      cyc(0, '0, 0, k, 0);
   endtask

   task automatic clear_stat;
      cyc(0, '0, 0, 4'b0000, 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      expect_out("R1 reset state", 6'b00_0_0_0_0);

      // exact lane A, pending then completion
      access(32'h1000);
      expect_out("R6 match held pending", 6'b00_0_0_0_0);
      end_ins(4'b0001);
      expect_out("R2 R6 lane A precise event", 6'b01_0_1_1_1);
      @(negedge clk); #1;
      expect_out("R6 event is one pulse", 6'b01_0_0_0_0);
      clear_stat;
      expect_out("R11 clear", 6'b00_0_0_0_0);

      // qualifiers
      cmp_qual_a = 6'b111101; acc_store = 1;
      access(32'h1000); end_ins(4'b0001);
      expect_out("R3 store disabled", 6'b00_0_0_0_0);
      acc_store = 0; cmp_qual_a = 6'b011111; acc_space = 1;
      access(32'h1000); end_ins(4'b0001);
      expect_out("R3 space 1 disabled", 6'b00_0_0_0_0);
      acc_space = 0; cmp_qual_a = 6'b110111; acc_super = 1;
      access(32'h1000); end_ins(4'b0001);
      expect_out("R3 supervisor disabled", 6'b00_0_0_0_0);
      acc_super = 0;
      access(32'h1000); end_ins(4'b0001);
      expect_out("R3 user enabled", 6'b01_0_1_1_1);
      clear_stat; cmp_qual_a = 6'h3F;

      // lane B and accumulation
      access(32'h2000); end_ins(4'b0001);
      expect_out("R2 lane B", 6'b10_0_1_1_1);
      clear_stat;
      access(32'h1000); access(32'h2000); end_ins(4'b0001);
      expect_out("R6 two accesses gathered", 6'b11_0_1_1_1);
      clear_stat;

      // masked
      cmp_mode = 2'd1; cmp_val_a = 32'h1230; cmp_val_b = 32'h0FF0;
      access(32'h1330); end_ins(4'b0001);
      expect_out("R4 masked miss", 6'b00_0_0_0_0);
      access(32'h5237); end_ins(4'b0001);
      expect_out("R4 masked hit", 6'b11_0_1_1_1);
      clear_stat;

      // ranges
      cmp_mode = 2'd2; cmp_val_a = 32'h100; cmp_val_b = 32'h200;
      access(32'h200); end_ins(4'b0001);
      expect_out("R5 upper bound excluded", 6'b00_0_0_0_0);
      access(32'h1FF); end_ins(4'b0001);
      expect_out("R5 top inside", 6'b11_0_1_1_1);
      clear_stat;
      access(32'h100); end_ins(4'b0001);
      expect_out("R5 lower bound included", 6'b11_0_1_1_1);
      clear_stat;
      cmp_mode = 2'd3;
      access(32'h150); end_ins(4'b0001);
      expect_out("R5 outside miss", 6'b00_0_0_0_0);
      access(32'h200); end_ins(4'b0001);
      expect_out("R5 outside hit", 6'b11_0_1_1_1);
      clear_stat;

      // storage exception
      cmp_mode = 2'd0; cmp_val_a = 32'h1000; cmp_val_b = 32'h2000;
      access(32'h1000); end_ins(4'b0011);
      expect_out("R7 imprecise event", 6'b01_1_1_0_1);
      clear_stat;
      expect_out("R11 imprecise cleared", 6'b00_0_0_0_0);

      // global enable off
      dbg_global_en = 0;
      access(32'h1000); end_ins(4'b0001);
      expect_out("R8 status without irq", 6'b01_0_1_1_0);
      dbg_global_en = 1; clear_stat;

      // split second half
      cyc(1, 32'h1000, 1, 4'b0000, 0); end_ins(4'b0001);
      expect_out("R9 second half ignored", 6'b00_0_0_0_0);

      // discards
      access(32'h1000); end_ins(4'b1000);
      expect_out("R10 interrupt abort", 6'b00_0_0_0_0);
      access(32'h2000); end_ins(4'b0100);
      expect_out("R10 flush", 6'b00_0_0_0_0);
      end_ins(4'b0001);
      expect_out("R10 nothing left pending", 6'b00_0_0_0_0);
      cyc(1, 32'h1000, 0, 4'b0101, 0);
      expect_out("R10 flush beats complete", 6'b00_0_0_0_0);
      end_ins(4'b0001);
      expect_out("R12 end without match", 6'b00_0_0_0_0);

      // clear racing a report
      access(32'h2000); end_ins(4'b0001);
      expect_out("R11 sticky set", 6'b10_0_1_1_1);
      cyc(1, 32'h1000, 0, 4'b0001, 1);
      expect_out("R11 clear with new report", 6'b01_0_1_1_1);
      clear_stat;

      // random phase against the model
      for (int seg = 0; seg < 40; seg++) begin
         @(negedge clk);
         cmp_mode   = 2'($urandom_range(0, 3));
         cmp_val_a  = 32'($urandom_range(0, 255));
         cmp_val_b  = 32'($urandom_range(0, 255));
         cmp_qual_a = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 63)) : 6'h3F;
         cmp_qual_b = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 63)) : 6'h3F;
         for (int k = 0; k < 25; k++) begin
            int pick;
            @(negedge clk);
            pick = $urandom_range(0, 3);
            acc_valid = ($urandom_range(0, 2) != 0);
            acc_addr  = (pick == 0) ? cmp_val_a : (pick == 1) ? cmp_val_b : 32'($urandom_range(0, 255));
            acc_store = 1'($urandom_range(0, 1));
            acc_super = 1'($urandom_range(0, 1));
            acc_space = 1'($urandom_range(0, 1));
            acc_second_half = ($urandom_range(0, 5) == 0);
            ins_complete    = ($urandom_range(0, 3) == 0);
            ins_dsi         = ($urandom_range(0, 7) == 0);
            ins_flush       = ($urandom_range(0, 11) == 0);
            ins_intr_abort  = ($urandom_range(0, 11) == 0);
            stat_clr        = ($urandom_range(0, 9) == 0);
            dbg_global_en   = ($urandom_range(0, 4) != 0);
         end
      end
      @(negedge clk);
      acc_valid = 0; ins_complete = 0; ins_dsi = 0; ins_flush = 0; ins_intr_abort = 0; stat_clr = 0;
      repeat (3) @(negedge clk);
      #1;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule